// File: doc/BRIEF.md
# UART Host Register File with Switchable FIFOs

This block is the processor-facing side of a classic byte-wide serial port. A host reaches eight byte registers through a 3-bit offset: receive/transmit data, interrupt enable, interrupt identification and FIFO control, line control, modem control, line status, modem status and a scratch byte. A latch bit in the line control register swaps the two lowest offsets over to the baud divisor. The block holds a transmit queue and a receive queue. Each queue is one entry deep in the legacy mode and sixteen entries deep once FIFO mode is switched on.

Serializer logic attaches through simple ports. It pulls characters from the transmit queue with a pop strobe, and it pushes received characters together with an error byte into the receive queue. The block also works out how many clock ticks one character occupies on the line, for the current divisor and frame format, and hands that figure to the serializer. Interrupt encoding is done elsewhere: its identification code comes in on a port and is returned when the host reads that offset.

Top module: `uart_regfile`

## Requirements
- R1: After reset, line control reads 0x03, line status reads 0x60 (bit 5 transmit queue empty, bit 6 transmitter empty while `tx_idle` is high), and interrupt enable, scratch, modem status and `char_ticks` are all 0.
- R2: While line control bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte. A read of offset 0 pops nothing, a write to offset 0 queues nothing, and the interrupt enable is left untouched.
- R3: `char_ticks` equals divisor × bits per character, with any half tick dropped. Bits per character are 1 start bit, 5 + LCR[1:0] data bits, 1 more if LCR[3] (parity) is set, and stop bits of 2 when LCR[2] is set, otherwise 1.5 when LCR[1:0]=0 and 1 in all other cases. The value is valid one cycle after the write.
- R4: FCR bit 0 selects a queue depth of 16 (when 1) or 1 (when 0). Any write that changes this bit empties both queues and clears data-ready.
- R5: A write to offset 2 with bit 1 set empties the receive queue and clears data-ready. With bit 2 set it empties the transmit queue.
- R6: A data write to a full transmit queue replaces the newest entry and leaves the count unchanged. After any data write, line status bits 5 and 6 read 0.
- R7: Reading line status returns it and then clears bits 1 (overrun), 2 (parity), 3 (framing), 4 (break) and 7 (receive error). Bits set in `msr_in` accumulate in modem status, and reading modem status returns the value and then clears it.
- R8: Modem control always reads 0, while its written value still appears on `modem_ctrl`. The scratch byte reads back the last value written.
- R9: Reading offset 0 returns the head character and pops it if one is present. Data-ready then shows whether entries remain, and `rx_idle_ticks` is cleared.
- R10: A push into a full receive queue drops the character and sets line status bits 1 and 7. Data-ready (bit 0) is set after any push.
- R11: The error byte of a receive entry (bits 1 to 4 kept, with bit 7 added when any of them is set) is ORed into line status when that entry reaches the head. It is then removed from the entry, so it appears only once.
- R12: Pushed data is masked to the configured word length of 5 + LCR[1:0] bits.
- R13: `rx_idle_ticks` counts cycles while data-ready is set and returns to 0 on every push or data read.
- R14: Offset 2 reads {FCR0, FCR0, 2'b00, `irq_id`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current access |
| irq_id | input | 4 | Identification code from the interrupt encoder |
| msr_in | input | 8 | Modem status bits to set |
| tx_data | output | 8 | Head of the transmit queue |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_pop | input | 1 | Serializer takes the head character |
| tx_idle | input | 1 | Serializer shift register empty |
| tx_level | output | 5 | Transmit queue count |
| rx_push | input | 1 | Serializer delivers a character |
| rx_data | input | 8 | Received character |
| rx_err | input | 8 | Error bits in line status positions |
| rx_level | output | 5 | Receive queue count |
| line_ctrl | output | 8 | Line control register |
| char_ticks | output | 20 | Clock ticks per character |
| int_enable | output | 4 | Interrupt enable register |
| modem_ctrl | output | 5 | Modem control register |
| line_status | output | 8 | Line status as read |
| modem_status | output | 8 | Modem status register |
| fifo_enabled | output | 1 | Sixteen-entry mode active |
| rx_trigger | output | 2 | Receive trigger level field |
| rx_idle_ticks | output | 16 | Cycles since the last receive activity while data is pending |

## Verification
The hardest state to reach is an error byte being merged into line status. The error must arrive on a character that sits behind a clean one, so that the merge happens only when the earlier character is read. The bench queues a clean character and then a flagged one, and confirms that the flag is absent before the read, present after the head moves, and gone on the next status read. Overflow and replacement of the newest entry require a queue filled to exactly its configured depth. The bench drives one push or write past the limit in both the one-entry and the sixteen-entry mode, then drains the queue in order. The character-time formula is swept over every frame format for several divisors, including the largest.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_IEN   = 3'd1;
    localparam logic [2:0] OFS_FIFO  = 3'd2;
    localparam logic [2:0] OFS_LINE  = 3'd3;
    localparam logic [2:0] OFS_MODC  = 3'd4;
    localparam logic [2:0] OFS_LSTAT = 3'd5;
    localparam logic [2:0] OFS_MSTAT = 3'd6;
    localparam logic [2:0] OFS_SCR   = 3'd7;

    localparam int LS_DR   = 0;
    localparam int LS_OE   = 1;
    localparam int LS_PE   = 2;
    localparam int LS_FE   = 3;
    localparam int LS_BI   = 4;
    localparam int LS_THRE = 5;
    localparam int LS_TEMT = 6;
    localparam int LS_RXE  = 7;

    localparam logic [7:0] LS_ERR_MASK  = 8'h9E;
    localparam logic [7:0] LS_LINE_ERRS = 8'h1E;
    localparam logic [7:0] LINE_RESET   = 8'h03;
endpackage

// File: rtl/uart_char_time.sv
module uart_char_time #(
    parameter int DIV_W  = 16,
    parameter int TICK_W = DIV_W + 4
) (
    input  logic [DIV_W-1:0]  divisor,
    input  logic [7:0]        line_ctrl,
    output logic [TICK_W-1:0] ticks
);
    localparam int PROD_W = DIV_W + 5;

    logic [4:0]        half_bits;
    logic [2:0]        stop_half;
    logic [PROD_W-1:0] product;

    // Frame length in half-bit units so that 1.5 stop bits stays integral.
    always_comb begin
        if (line_ctrl[2])
            stop_half = 3'd4;
        else if (line_ctrl[1:0] == 2'b00)
            stop_half = 3'd3;
        else
            stop_half = 3'd2;
        half_bits = 5'd2 + 5'd10 + {2'b00, line_ctrl[1:0], 1'b0}
                  + {3'b000, line_ctrl[3], 1'b0} + {2'b00, stop_half};
        product   = PROD_W'(divisor) * PROD_W'(half_bits);
        ticks     = TICK_W'(product >> 1);
    end
endmodule

// File: rtl/uart_rf_fifo.sv
module uart_rf_fifo #(
    parameter int WIDTH     = 8,
    parameter int DEPTH     = 16,
    parameter bit OVERWRITE = 1'b0,
    parameter int KEEP_W    = WIDTH
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wide,
    input  logic                      flush,
    input  logic                      push,
    input  logic [WIDTH-1:0]          push_data,
    input  logic                      pop,
    input  logic                      clr_head,
    output logic [WIDTH-1:0]          head_data,
    output logic [$clog2(DEPTH):0]    level,
    output logic                      empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0]    DEPTH_C   = CW'(DEPTH);
    localparam logic [WIDTH-1:0] KEEP_MASK = WIDTH'((64'd1 << KEEP_W) - 64'd1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               wr;
        logic [AW-1:0]               rd;
        logic [CW-1:0]               cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [CW-1:0] cap;
    logic          full, do_pop, push_ok;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p, input logic w);
        if (!w || p == AW'(DEPTH - 1)) return '0;
        return p + AW'(1);
    endfunction

    function automatic logic [AW-1:0] ptr_dec(input logic [AW-1:0] p, input logic w);
        if (!w) return '0;
        if (p == '0) return AW'(DEPTH - 1);
        return p - AW'(1);
    endfunction

    assign cap     = wide ? DEPTH_C : CW'(1);
    assign full    = (st_q.cnt >= cap);
    assign do_pop  = pop && (st_q.cnt != '0);
    assign push_ok = push && (!full || do_pop);

    always_comb begin
        st_d = st_q;
        if (clr_head && (st_q.cnt != '0) && !do_pop)
            st_d.mem[st_q.rd] = st_q.mem[st_q.rd] & KEEP_MASK;
        if (do_pop)
            st_d.rd = ptr_inc(st_q.rd, wide);
        if (push_ok) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr = ptr_inc(st_q.wr, wide);
        end else if (push && OVERWRITE) begin
            st_d.mem[ptr_dec(st_q.wr, wide)] = push_data;
        end
        st_d.cnt = st_q.cnt + CW'(push_ok) - CW'(do_pop);
        if (flush) begin
            st_d.wr  = '0;
            st_d.rd  = '0;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_data = st_q.mem[st_q.rd];
    assign level     = st_q.cnt;
    assign empty     = (st_q.cnt == '0);

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= DEPTH_C)
        else $error("queue count beyond depth");

    assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0))
        else $error("flush left entries");
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
    import uart_rf_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int IDLE_W     = 16,
    parameter int DIV_W      = 16,
    parameter int TICK_W     = DIV_W + 4,
    parameter int LVL_W      = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [3:0]        irq_id,
    input  logic [7:0]        msr_in,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_pop,
    input  logic              tx_idle,
    output logic [LVL_W-1:0]  tx_level,
    input  logic              rx_push,
    input  logic [7:0]        rx_data,
    input  logic [7:0]        rx_err,
    output logic [LVL_W-1:0]  rx_level,
    output logic [7:0]        line_ctrl,
    output logic [TICK_W-1:0] char_ticks,
    output logic [3:0]        int_enable,
    output logic [4:0]        modem_ctrl,
    output logic [7:0]        line_status,
    output logic [7:0]        modem_status,
    output logic              fifo_enabled,
    output logic [1:0]        rx_trigger,
    output logic [IDLE_W-1:0] rx_idle_ticks
);
    localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(FIFO_DEPTH);

    typedef struct packed {
        logic [7:0]        div_lo;
        logic [7:0]        div_hi;
        logic [3:0]        ien;
        logic              fen;
        logic [1:0]        trig;
        logic [7:0]        lcr;
        logic [4:0]        mcr;
        logic              dr;
        logic [7:0]        err;
        logic [7:0]        msr;
        logic [7:0]        scr;
        logic [IDLE_W-1:0] idle;
    } regs_t;

    regs_t r_d, r_q;

    logic        wr_acc, rd_acc, dlab;
    logic        thr_wr, rbr_rd, lsr_rd, msr_rd, fcr_wr, mode_chg;
    logic        rx_flush, tx_flush, rx_full, rx_pop_eff, overrun, merge_en;
    logic        rx_empty, tx_empty;
    logic [7:0]  wl_mask;
    logic [15:0] rx_head, rx_entry;
    logic [7:0]  head_err;

    assign wr_acc     = bus_sel && bus_wr;
    assign rd_acc     = bus_sel && !bus_wr;
    assign dlab       = r_q.lcr[7];
    assign thr_wr     = wr_acc && (bus_addr == OFS_DATA) && !dlab;
    assign rbr_rd     = rd_acc && (bus_addr == OFS_DATA) && !dlab;
    assign lsr_rd     = rd_acc && (bus_addr == OFS_LSTAT);
    assign msr_rd     = rd_acc && (bus_addr == OFS_MSTAT);
    assign fcr_wr     = wr_acc && (bus_addr == OFS_FIFO);
    assign mode_chg   = fcr_wr && (bus_wdata[0] != r_q.fen);
    assign rx_flush   = fcr_wr && (bus_wdata[1] || mode_chg);
    assign tx_flush   = fcr_wr && (bus_wdata[2] || mode_chg);
    assign rx_full    = (rx_level >= (r_q.fen ? DEPTH_L : LVL_W'(1)));
    assign rx_pop_eff = rbr_rd && !rx_empty;
    assign overrun    = rx_push && rx_full && !rx_pop_eff && !rx_flush;
    assign merge_en   = !rx_empty && !rx_pop_eff && !rx_flush;
    assign head_err   = rx_head[15:8];
    assign wl_mask    = 8'hFF >> (2'd3 - r_q.lcr[1:0]);
    assign rx_entry   = {rx_err & LS_ERR_MASK, rx_data & wl_mask};

    uart_rf_fifo #(
        .WIDTH(16), .DEPTH(FIFO_DEPTH), .OVERWRITE(1'b0), .KEEP_W(8)
    ) u_rxq (
        .clk(clk), .rst_n(rst_n), .wide(r_q.fen), .flush(rx_flush),
        .push(rx_push), .push_data(rx_entry), .pop(rbr_rd), .clr_head(1'b1),
        .head_data(rx_head), .level(rx_level), .empty(rx_empty)
    );

    uart_rf_fifo #(
        .WIDTH(8), .DEPTH(FIFO_DEPTH), .OVERWRITE(1'b1), .KEEP_W(8)
    ) u_txq (
        .clk(clk), .rst_n(rst_n), .wide(r_q.fen), .flush(tx_flush),
        .push(thr_wr), .push_data(bus_wdata), .pop(tx_pop), .clr_head(1'b0),
        .head_data(tx_data), .level(tx_level), .empty(tx_empty)
    );

    uart_char_time #(.DIV_W(DIV_W), .TICK_W(TICK_W)) u_ctime (
        .divisor({r_q.div_hi, r_q.div_lo}), .line_ctrl(r_q.lcr), .ticks(char_ticks)
    );

    always_comb begin
        r_d = r_q;
        if (wr_acc) begin
            case (bus_addr)
                OFS_DATA:  if (dlab) r_d.div_lo = bus_wdata;
                OFS_IEN:   if (dlab) r_d.div_hi = bus_wdata;
                           else      r_d.ien    = bus_wdata[3:0];
                OFS_FIFO:  begin
                               r_d.fen  = bus_wdata[0];
                               r_d.trig = bus_wdata[7:6];
                           end
                OFS_LINE:  r_d.lcr = bus_wdata;
                OFS_MODC:  r_d.mcr = bus_wdata[4:0];
                OFS_SCR:   r_d.scr = bus_wdata;
                default:   ;
            endcase
        end
        // Sticky error bits: a status read clears, new events in the same cycle win.
        r_d.err = lsr_rd ? 8'h00 : r_q.err;
        if (merge_en) begin
            r_d.err = r_d.err | (head_err & LS_ERR_MASK);
            if (|(head_err & LS_LINE_ERRS)) r_d.err[LS_RXE] = 1'b1;
        end
        if (overrun) begin
            r_d.err[LS_OE]  = 1'b1;
            r_d.err[LS_RXE] = 1'b1;
        end
        if (rx_flush)     r_d.dr = 1'b0;
        else if (rx_push) r_d.dr = 1'b1;
        else if (rbr_rd)  r_d.dr = (rx_level > LVL_W'(1));
        if (rx_push || rbr_rd || rx_flush) r_d.idle = '0;
        else if (r_q.dr && (r_q.idle != '1)) r_d.idle = r_q.idle + IDLE_W'(1);
        r_d.msr = (msr_rd ? 8'h00 : r_q.msr) | msr_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.lcr <= LINE_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        line_status          = r_q.err;
        line_status[LS_DR]   = r_q.dr;
        line_status[LS_THRE] = tx_empty;
        line_status[LS_TEMT] = tx_empty && tx_idle;
    end

    always_comb begin
        case (bus_addr)
            OFS_DATA:  bus_rdata = dlab ? r_q.div_lo : (rx_empty ? 8'h00 : rx_head[7:0]);
            OFS_IEN:   bus_rdata = dlab ? r_q.div_hi : {4'h0, r_q.ien};
            OFS_FIFO:  bus_rdata = {r_q.fen, r_q.fen, 2'b00, irq_id};
            OFS_LINE:  bus_rdata = r_q.lcr;
            OFS_MODC:  bus_rdata = 8'h00;
            OFS_LSTAT: bus_rdata = line_status;
            OFS_MSTAT: bus_rdata = r_q.msr;
            default:   bus_rdata = r_q.scr;
        endcase
    end

    assign tx_valid      = !tx_empty;
    assign line_ctrl     = r_q.lcr;
    assign int_enable    = r_q.ien;
    assign modem_ctrl    = r_q.mcr;
    assign modem_status  = r_q.msr;
    assign fifo_enabled  = r_q.fen;
    assign rx_trigger    = r_q.trig;
    assign rx_idle_ticks = r_q.idle;

    assert_thr_clears_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> (!line_status[LS_THRE] && !line_status[LS_TEMT]))
        else $error("data write left empty flags set");

    assert_push_sets_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !rx_flush) |=> line_status[LS_DR])
        else $error("push did not set data-ready");

    assert_msr_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && (msr_in == 8'h00)) |=> (modem_status == 8'h00))
        else $error("modem status not cleared by read");

    assert_scratch_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && (bus_addr == OFS_SCR)) |=> (r_q.scr == $past(bus_wdata)))
        else $error("scratch lost write");

    assert_overrun_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> (line_status[LS_OE] && line_status[LS_RXE]))
        else $error("overrun not flagged");
endmodule

// File: tb/uart_regfile_test.sv
`timescale 1ns/1ps
module uart_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0, bus_rdata;
    logic [3:0]  irq_id = 4'h4;
    logic [7:0]  msr_in = '0;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_pop = 1'b0, tx_idle = 1'b1;
    logic [4:0]  tx_level, rx_level;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_data = '0, rx_err = '0;
    logic [7:0]  line_ctrl, line_status, modem_status;
    logic [19:0] char_ticks;
    logic [3:0]  int_enable;
    logic [4:0]  modem_ctrl;
    logic        fifo_enabled;
    logic [1:0]  rx_trigger;
    logic [15:0] rx_idle_ticks;

    uart_regfile uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_id(irq_id), .msr_in(msr_in), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_pop(tx_pop), .tx_idle(tx_idle), .tx_level(tx_level), .rx_push(rx_push),
        .rx_data(rx_data), .rx_err(rx_err), .rx_level(rx_level), .line_ctrl(line_ctrl),
        .char_ticks(char_ticks), .int_enable(int_enable), .modem_ctrl(modem_ctrl),
        .line_status(line_status), .modem_status(modem_status),
        .fifo_enabled(fifo_enabled), .rx_trigger(rx_trigger), .rx_idle_ticks(rx_idle_ticks)
    );

    always #2.5 clk = ~clk;

    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;
    logic [7:0] rv;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic push(input logic [7:0] d, input logic [7:0] e);
        @(negedge clk);
        rx_push = 1'b1; rx_data = d; rx_err = e;
        @(negedge clk);
        rx_push = 1'b0; rx_err = '0;
    endtask

    task automatic pop_tx(output logic [7:0] d);
        @(negedge clk);
        d = tx_data; tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int divs[7];
        divs = '{1, 2, 3, 7, 12, 256, 65535};
        idle(4);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(3, rv); check("R1 lcr", rv, 8'h03);
        rd(1, rv); check("R1 ier", rv, 0);
        rd(5, rv); check("R1 lsr", rv, 8'h60);
        rd(7, rv); check("R1 scr", rv, 0);
        rd(6, rv); check("R1 msr", rv, 0);
        check("R1 ticks", char_ticks, 0);

        // R8 scratch and modem control
        wr(7, 8'h5A); rd(7, rv); check("R8 scr", rv, 8'h5A);
        wr(4, 8'h1F); rd(4, rv); check("R8 mcr read", rv, 0);
        check("R8 mcr port", modem_ctrl, 5'h1F);

        // R14 identification read, FIFO off
        rd(2, rv); check("R14 iir off", rv, 8'h04);

        // R3 sweep over every frame format
        for (int l = 0; l < 16; l++) begin
            for (int k = 0; k < 7; k++) begin
                int hb, exp;
                wr(3, 8'h80 | 8'(l));
                wr(0, 8'(divs[k]));
                wr(1, 8'(divs[k] >> 8));
                hb  = 2 + 2 * (5 + (l & 3)) + 2 * ((l >> 3) & 1)
                    + (((l >> 2) & 1) != 0 ? 4 : ((l & 3) == 0 ? 3 : 2));
                exp = (divs[k] * hb) >> 1;
                check("R3 ticks", char_ticks, exp);
            end
        end

        // R2 divisor aliasing
        wr(3, 8'h83); wr(0, 8'h34); wr(1, 8'h12);
        rd(0, rv); check("R2 dll", rv, 8'h34);
        rd(1, rv); check("R2 dlh", rv, 8'h12);
        check("R2 no thr", tx_valid, 0);
        check("R2 ier kept", int_enable, 0);
        check("R3 ticks 8N1", char_ticks, 16'h1234 * 10);
        wr(3, 8'h03);
        rd(1, rv); check("R2 ier view", rv, 0);

        // R10 / R9 / R7 one-entry mode
        push(8'h41, 0); push(8'h42, 0);
        rd(5, rv); check("R10 overrun lsr", rv, 8'hE3);
        rd(5, rv); check("R7 errors cleared", rv, 8'h61);
        rd(0, rv); check("R9 first kept", rv, 8'h41);
        rd(5, rv); check("R9 dr cleared", rv, 8'h60);

        // R12 word length mask
        wr(3, 8'h00); push(8'hFF, 0);
        rd(0, rv); check("R12 5-bit", rv, 8'h1F);
        wr(3, 8'h02); push(8'hFF, 0);
        rd(0, rv); check("R12 7-bit", rv, 8'h7F);
        wr(3, 8'h03);

        // R13 idle counter
        push(8'h55, 0);
        check("R13 cleared on push", rx_idle_ticks, 0);
        idle(5);
        check("R13 counts", rx_idle_ticks, 5);
        rd(0, rv);
        check("R13 cleared on read", rx_idle_ticks, 0);

        // R6 one-entry transmit
        wr(0, 8'h11);
        rd(5, rv); check("R6 flags low", rv, 8'h00);
        wr(0, 8'h22);
        check("R6 overwrite", tx_data, 8'h22);
        check("R6 count", tx_level, 1);
        pop_tx(rv);
        rd(5, rv); check("R6 empty again", rv, 8'h60);

        // R4 sixteen-entry mode
        wr(2, 8'h01);
        check("R4 enabled", fifo_enabled, 1);
        rd(2, rv); check("R14 iir on", rv, 8'hC4);
        for (int i = 0; i < 17; i++) push(8'(i * 7 + 3), 0);
        check("R4 rx depth", rx_level, 16);
        rd(5, rv); check("R10 overrun 16", rv, 8'hE3);
        for (int i = 0; i < 16; i++) begin
            rd(0, rv); check("R9 order", rv, (i * 7 + 3) & 8'hFF);
        end
        rd(5, rv); check("R9 drained", rv, 8'h60);
        for (int i = 0; i < 16; i++) wr(0, 8'(8'h80 + i));
        wr(0, 8'hEE);
        check("R6 tx depth", tx_level, 16);
        for (int i = 0; i < 16; i++) begin
            pop_tx(rv); check("R6 tx order", rv, (i == 15) ? 8'hEE : 8'h80 + i);
        end
        check("R6 tx empty", tx_valid, 0);

        // R11 per-entry error merge
        push(8'h10, 0); push(8'h20, 8'h08);
        idle(2);
        rd(5, rv); check("R11 not yet", rv, 8'h61);
        rd(0, rv); check("R11 first", rv, 8'h10);
        idle(1);
        rd(5, rv); check("R11 merged", rv, 8'hE9);
        rd(5, rv); check("R11 once", rv, 8'h61);
        rd(0, rv); check("R11 second", rv, 8'h20);

        // R5 resets
        push(1, 0); push(2, 0); push(3, 0);
        wr(2, 8'h03);
        check("R5 rx empty", rx_level, 0);
        rd(5, rv); check("R5 dr", rv, 8'h60);
        wr(0, 8'h01); wr(0, 8'h02);
        wr(2, 8'h05);
        check("R5 tx empty", tx_level, 0);

        // R4 mode change flushes
        push(4, 0); push(5, 0); wr(0, 8'h09);
        wr(2, 8'h00);
        check("R4 disabled", fifo_enabled, 0);
        check("R4 rx flushed", rx_level, 0);
        check("R4 tx flushed", tx_level, 0);
        rd(5, rv); check("R4 dr cleared", rv, 8'h60);

        // R7 modem status
        @(negedge clk) msr_in = 8'h09;
        @(negedge clk) msr_in = 8'h00;
        rd(6, rv); check("R7 msr set", rv, 8'h09);
        rd(6, rv); check("R7 msr cleared", rv, 8'h00);

        // R2 read with latch open does not pop
        push(8'h77, 0);
        wr(3, 8'h83);
        rd(0, rv); check("R2 dll view", rv, 8'h34);
        check("R2 no pop", rx_level, 1);
        wr(3, 8'h03);
        rd(0, rv); check("R9 after latch", rv, 8'h77);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule